// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table in memory. A client offers a request with a valid/ready handshake. The request carries the address, a write flag and a user-mode flag. The walker reads a directory entry and then a table entry through a single memory request/response port. It checks each entry for presence and permission. On a successful translation it writes back the accessed and dirty flags, and then it returns either a physical address or a page fault with a cause code and the level at which the fault occurred.

A base-register input points at the directory. A paging-enable input lets the block pass addresses through untranslated. Only one request is in flight at a time. The memory port issues a one-cycle request pulse and then waits for a one-cycle response pulse, for both reads and writes. Pages are 4 KB and each level holds 1024 four-byte entries.

Top module: `ptw_top`

## Requirements
- R1: `req_ready` is high only while the walker is idle. Each memory request is a single-cycle pulse, and no new memory request is issued until the previous one has received its response.
- R2: When `paging_en` is low at acceptance, `rsp_valid` rises in the cycle after acceptance with `rsp_paddr` equal to the linear address, `rsp_fault` low and no memory access made.
- R3: The directory entry is read from {base[31:12], va[31:22], 2'b00}. The table entry is read from {dir_entry[31:12], va[21:12], 2'b00}. The physical address is {tbl_entry[31:12], va[11:0]}.
- R4: Bits 11:0 of `base_reg` have no effect on the translation.
- R5: An entry with bit 0 (present) clear ends the walk with a fault of cause 1. `rsp_level` reads 0 for the directory entry and 1 for the table entry. A directory fault makes exactly one memory read.
- R6: A user access (`req_user`=1) to an entry whose bit 2 (user) is clear faults with cause 3. Supervisor accesses ignore bit 2.
- R7: A user write to an entry whose bit 1 (writable) is clear faults with cause 2. Supervisor writes and user reads ignore bit 1. Within one entry, not-present takes precedence over user protection, which takes precedence over write protection.
- R8: After a successful translation, bit 5 (accessed) is set in each entry that has it clear, and bit 6 (dirty) is set in the table entry on a write. Each entry needs at most one memory write, the directory entry is written first, and all writes complete before `rsp_valid`.
- R9: No flag write-back happens for a faulting request, nor for an entry whose required flags are already set.
- R10: Cause code 0 accompanies every successful response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Translation enable, sampled at request acceptance |
| base_reg | input | 32 | Directory base; only bits 31:12 are used |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write protect, 3 user protect |
| rsp_level | output | 1 | Fault level: 0 directory, 1 table |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_we | output | 1 | 1 = write |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry value |
| mem_rsp_valid | input | 1 | Memory response / write acknowledge pulse |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
With the bench memory answering one cycle after each request, every result has a fixed due cycle counted from the first falling edge after acceptance. A pass-through result is due at offset 0, a directory fault at offset 3, a table fault at offset 6, and a success at offset 8 plus 2 for each flag write-back. Each scenario task measures this offset and compares it with the value computed from the requirement. Each task also counts the memory reads and writes made between acceptance and response and checks those counts. All outputs and memory contents are sampled on falling edges.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PAGE_BITS = 12;
  localparam int ENTRY_LOG = 2;
  localparam int IDX_BITS  = PAGE_BITS - ENTRY_LOG;
  localparam int ADDR_W    = PAGE_BITS + 2 * IDX_BITS;
  localparam int FRAME_W   = ADDR_W - PAGE_BITS;
  localparam int LEVELS    = 2;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY    = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_TBL, ST_UPD, ST_RSP
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ABSENT  = 2'd1,
    FLT_WRPROT  = 2'd2,
    FLT_USRPROT = 2'd3
  } fault_e;
endpackage

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] entry,
  input  logic              is_write,
  input  logic              is_user,
  output logic              fault,
  output fault_e            cause
);
  always_comb begin
    cause = FLT_NONE;
    if (!entry[BIT_PRESENT])
      cause = FLT_ABSENT;
    else if (is_user && !entry[BIT_USER])
      cause = FLT_USRPROT;
    else if (is_user && is_write && !entry[BIT_WRITABLE])
      cause = FLT_WRPROT;
    fault = (cause != FLT_NONE);
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  output logic [ADDR_W-1:0]  dir_addr,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [ADDR_W-1:0]  phys_addr
);
  localparam int HI_TOP = ADDR_W - 1;
  localparam int MID_TOP = ADDR_W - IDX_BITS - 1;

  assign dir_addr  = {base_frame, vaddr[HI_TOP -: IDX_BITS], {ENTRY_LOG{1'b0}}};
  assign tbl_addr  = {dir_frame, vaddr[MID_TOP -: IDX_BITS], {ENTRY_LOG{1'b0}}};
  assign phys_addr = {tbl_frame, vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd
  import ptw_pkg::*;
#(
  parameter bit WITH_DIRTY = 1'b0
) (
  input  logic [ADDR_W-1:0] entry,
  input  logic              is_write,
  output logic              need_wb,
  output logic [ADDR_W-1:0] new_entry
);
  logic set_dirty;

  generate
    if (WITH_DIRTY) begin : g_dirty
      assign set_dirty = is_write;
    end else begin : g_nodirty
      assign set_dirty = 1'b0;
    end
  endgenerate

  always_comb begin
    new_entry = entry;
    new_entry[BIT_ACCESSED] = 1'b1;
    if (set_dirty) new_entry[BIT_DIRTY] = 1'b1;
    need_wb = (new_entry != entry);
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 paging_en,
  input  logic [ADDR_W-1:0]    base_reg,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_vaddr,
  input  logic                 req_write,
  input  logic                 req_user,
  output logic                 rsp_valid,
  output logic [ADDR_W-1:0]    rsp_paddr,
  output logic                 rsp_fault,
  output logic [1:0]           rsp_cause,
  output logic                 rsp_level,
  output logic                 mem_req_valid,
  output logic                 mem_req_we,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [ADDR_W-1:0]    mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [ADDR_W-1:0]    mem_rsp_rdata
);
  walk_state_e                   state;
  logic [FRAME_W-1:0]            base_q;
  logic [ADDR_W-1:0]             va_q;
  logic                          wr_q, usr_q;
  logic                          pend;
  logic                          upd_lvl;
  logic [LEVELS-1:0][ADDR_W-1:0] ent_q;

  logic [ADDR_W-1:0]             dir_addr, tbl_addr, phys_addr;
  logic                          chk_fault;
  fault_e                        chk_cause;
  logic [LEVELS-1:0]             need_wb;
  logic [LEVELS-1:0][ADDR_W-1:0] new_ent;

  ptw_addr_gen u_addr (
    .base_frame (base_q),
    .vaddr      (va_q),
    .dir_frame  (ent_q[0][ADDR_W-1:PAGE_BITS]),
    .tbl_frame  (ent_q[1][ADDR_W-1:PAGE_BITS]),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .phys_addr  (phys_addr)
  );

  ptw_entry_chk u_chk (
    .entry    (mem_rsp_rdata),
    .is_write (wr_q),
    .is_user  (usr_q),
    .fault    (chk_fault),
    .cause    (chk_cause)
  );

  generate
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      ptw_flag_upd #(.WITH_DIRTY(lv == LEVELS - 1)) u_upd (
        .entry     (ent_q[lv]),
        .is_write  (wr_q),
        .need_wb   (need_wb[lv]),
        .new_entry (new_ent[lv])
      );
    end
  endgenerate

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    mem_req_valid <= 1'b0;
    rsp_valid     <= 1'b0;
    if (rst) begin
      state         <= ST_IDLE;
      base_q        <= '0;
      va_q          <= '0;
      wr_q          <= 1'b0;
      usr_q         <= 1'b0;
      pend          <= 1'b0;
      upd_lvl       <= 1'b0;
      ent_q         <= '0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b0;
      rsp_cause     <= FLT_NONE;
      rsp_level     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            base_q <= base_reg[ADDR_W-1:PAGE_BITS];
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            usr_q  <= req_user;
            pend   <= 1'b0;
            if (!paging_en) begin
              rsp_paddr <= req_vaddr;
              rsp_fault <= 1'b0;
              rsp_cause <= FLT_NONE;
              rsp_level <= 1'b0;
              rsp_valid <= 1'b1;
              state     <= ST_RSP;
            end else begin
              state <= ST_DIR;
            end
          end
        end
        ST_DIR, ST_TBL: begin
          if (!pend) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= (state == ST_DIR) ? dir_addr : tbl_addr;
            pend          <= 1'b1;
          end else if (mem_rsp_valid) begin
            pend <= 1'b0;
            ent_q[state == ST_TBL] <= mem_rsp_rdata;
            if (chk_fault) begin
              rsp_paddr <= '0;
              rsp_fault <= 1'b1;
              rsp_cause <= chk_cause;
              rsp_level <= (state == ST_TBL);
              rsp_valid <= 1'b1;
              state     <= ST_RSP;
            end else if (state == ST_DIR) begin
              state <= ST_TBL;
            end else begin
              upd_lvl <= 1'b0;
              state   <= ST_UPD;
            end
          end
        end
        ST_UPD: begin
          if (!pend && need_wb[upd_lvl]) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b1;
            mem_req_addr  <= upd_lvl ? tbl_addr : dir_addr;
            mem_req_wdata <= new_ent[upd_lvl];
            pend          <= 1'b1;
          end else if (!pend || mem_rsp_valid) begin
            pend <= 1'b0;
            if (upd_lvl) begin
              rsp_paddr <= phys_addr;
              rsp_fault <= 1'b0;
              rsp_cause <= FLT_NONE;
              rsp_level <= 1'b0;
              rsp_valid <= 1'b1;
              state     <= ST_RSP;
            end else begin
              upd_lvl <= 1'b1;
            end
          end
        end
        ST_RSP:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker bookkeeping: a write-back was issued for the current request
  logic wb_seen;
  always_ff @(posedge clk) begin
    if (rst || (req_valid && req_ready)) wb_seen <= 1'b0;
    else if (mem_req_valid && mem_req_we) wb_seen <= 1'b1;
  end

  // R1
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R1
  busy_port_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_en) |=>
      (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));
  // R3
  offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]);
  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> rsp_cause != FLT_NONE);
  // R8
  wb_accessed_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[BIT_ACCESSED]);
  // R9
  no_wb_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !wb_seen);
endmodule

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        paging_en = 1'b1;
  logic [31:0] base_reg = 32'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = 32'h0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        rsp_level;
  logic        mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #10 clk = ~clk;

  ptw_top u_dut (
    .clk(clk), .rst(rst), .paging_en(paging_en), .base_reg(base_reg),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_level(rsp_level),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // Memory model: 32 KB, one-cycle response, plus a bench poke port
  logic [31:0] mem [0:8191];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = 32'h0, tb_data = 32'h0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 8192; i++) mem[i] <= 32'h0;
    end else begin
      if (tb_we) mem[tb_addr[14:2]] <= tb_data;
      if (mem_req_valid) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_we) begin
          mem[mem_req_addr[14:2]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rsp_rdata <= mem[mem_req_addr[14:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // Results of the last request
  logic [31:0] r_pa;
  logic        r_flt, r_lvl;
  logic [1:0]  r_cause;
  int          r_lat, r_rd, r_wr;

  task automatic do_req(input logic [31:0] va, input logic wr, input logic usr);
    int rd0, wr0, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) begin
      failures++;
      $display("FAIL R1 no response actual=%0d expected=<200", n);
    end
    r_lat = n; r_pa = rsp_paddr; r_flt = rsp_fault; r_cause = rsp_cause; r_lvl = rsp_level;
    r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
  endtask

  task automatic t_reset();
    chk("R1 reset ready", {31'h0, req_ready}, 32'h1);
    chk("R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_bypass();
    paging_en = 1'b0;
    do_req(32'hDEAD_BEEF, 1'b1, 1'b1);
    chk("R2 bypass paddr", r_pa, 32'hDEAD_BEEF);
    chk("R2 bypass fault", {31'h0, r_flt}, 32'h0);
    chk("R2 bypass latency", r_lat, 0);
    chk("R2 bypass mem ops", r_rd + r_wr, 0);
    paging_en = 1'b1;
  endtask

  task automatic t_first_read();
    do_req(32'h0000_5123, 1'b0, 1'b1);
    chk("R3 translate paddr", r_pa, 32'h00AB_C123);
    chk("R10 success cause", {30'h0, r_cause}, 32'h0);
    chk("R8 reads", r_rd, 2);
    chk("R8 writes", r_wr, 2);
    chk("R8 latency", r_lat, 12);
    chk("R8 dir accessed", mem[0], 32'h0000_1027);
    chk("R8 tbl accessed no dirty", mem[1024 + 5], 32'h00AB_C027);
  endtask

  task automatic t_repeat_read();
    do_req(32'h0000_5123, 1'b0, 1'b1);
    chk("R9 flags set no wb", r_wr, 0);
    chk("R9 latency", r_lat, 8);
    chk("R3 repeat paddr", r_pa, 32'h00AB_C123);
  endtask

  task automatic t_sup_write_ro();
    do_req(32'h0000_6FFF, 1'b1, 1'b0);
    chk("R7 supervisor ignores RW", {31'h0, r_flt}, 32'h0);
    chk("R7 supervisor paddr", r_pa, 32'h00DE_FFFF);
    chk("R8 dirty write count", r_wr, 1);
    chk("R8 dirty entry", mem[1024 + 6], 32'h00DE_F065);
    chk("R8 latency one wb", r_lat, 10);
  endtask

  task automatic t_user_write_dirty();
    do_req(32'h0000_5123, 1'b1, 1'b1);
    chk("R8 user write ok", {31'h0, r_flt}, 32'h0);
    chk("R8 dirty added", mem[1024 + 5], 32'h00AB_C067);
    chk("R8 single wb", r_wr, 1);
  endtask

  task automatic t_absent();
    do_req(32'h0080_0000, 1'b1, 1'b1);
    chk("R5 dir absent cause", {30'h0, r_cause}, 32'h1);
    chk("R5 dir absent level", {31'h0, r_lvl}, 32'h0);
    chk("R5 dir absent reads", r_rd, 1);
    chk("R5 dir absent latency", r_lat, 3);
    do_req(32'h0000_7000, 1'b0, 1'b0);
    chk("R5 tbl absent cause", {30'h0, r_cause}, 32'h1);
    chk("R5 tbl absent level", {31'h0, r_lvl}, 32'h1);
    chk("R5 tbl absent reads", r_rd, 2);
    chk("R9 tbl absent no wb", r_wr, 0);
    chk("R5 tbl absent latency", r_lat, 6);
  endtask

  task automatic t_user_prot();
    do_req(32'h0000_8000, 1'b0, 1'b1);
    chk("R6 tbl user fault cause", {30'h0, r_cause}, 32'h3);
    chk("R6 tbl user fault level", {31'h0, r_lvl}, 32'h1);
    chk("R9 user fault no wb", r_wr, 0);
    do_req(32'h00C0_2008, 1'b1, 1'b1);
    chk("R6 dir user fault cause", {30'h0, r_cause}, 32'h3);
    chk("R6 dir user fault level", {31'h0, r_lvl}, 32'h0);
    chk("R9 dir entry untouched", mem[3], 32'h0000_3003);
    do_req(32'h00C0_2008, 1'b0, 1'b0);
    chk("R6 supervisor ok", {31'h0, r_flt}, 32'h0);
    chk("R6 supervisor paddr", r_pa, 32'h7777_7008);
  endtask

  task automatic t_write_prot();
    do_req(32'h0040_1040, 1'b1, 1'b1);
    chk("R7 dir write fault cause", {30'h0, r_cause}, 32'h2);
    chk("R7 dir write fault level", {31'h0, r_lvl}, 32'h0);
    chk("R9 write fault no wb", r_wr, 0);
    do_req(32'h0040_1040, 1'b0, 1'b1);
    chk("R7 user read ok", {31'h0, r_flt}, 32'h0);
    chk("R7 user read paddr", r_pa, 32'h5555_5040);
  endtask

  task automatic t_base();
    base_reg = 32'h0000_0FFF;
    do_req(32'h0000_5123, 1'b0, 1'b0);
    chk("R4 low base bits ignored", r_pa, 32'h00AB_C123);
    base_reg = 32'h0000_4ABC;
    do_req(32'h0000_5123, 1'b0, 1'b0);
    chk("R4 relocated directory", r_pa, 32'h9999_9123);
    chk("R4 relocated dir accessed", mem[4096], 32'h0000_3027);
    base_reg = 32'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    poke(32'h0000_0000, 32'h0000_1007);
    poke(32'h0000_0004, 32'h0000_2005);
    poke(32'h0000_000C, 32'h0000_3003);
    poke(32'h0000_1014, 32'h00AB_C007);
    poke(32'h0000_1018, 32'h00DE_F005);
    poke(32'h0000_1020, 32'h1234_5003);
    poke(32'h0000_2004, 32'h5555_5007);
    poke(32'h0000_3008, 32'h7777_7007);
    poke(32'h0000_3014, 32'h9999_9007);
    poke(32'h0000_4000, 32'h0000_3007);
    t_bypass();
    t_first_read();
    t_repeat_read();
    t_sup_write_ro();
    t_user_write_dirty();
    t_absent();
    t_user_prot();
    t_write_prot();
    t_base();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule